// File: doc/BRIEF.md
# Two-Phase Set-Associative Cache Controller

This block is a read/write cache placed between one requester port and one backing-memory port. It serves one access at a time. First it compares the tags of all ways in the selected set in parallel, with no wait state. Then it makes one access to a single line-wide data array, and that access always takes three cycles. A read returns the whole 32-byte line in one transfer. A write merges one 64-bit word into the line. The address is split into a tag, a set index and a 5-bit line offset.

On a miss the controller waits two cycles before it issues anything to memory. If the victim line is dirty, it first writes that line back as four ascending 64-bit beats. It then requests the whole line and collects four ascending response beats. It waits two more cycles before the fill goes into the data array. Replacement takes an invalid way first and otherwise follows a tree pseudo-LRU per set. The tree is updated on every hit and every fill. The policy is write-back with write-allocate.

A low enable input turns the cache off for that request. The access then bypasses the arrays entirely, but it still pays both two-cycle penalties.

Top module: `two_phase_cache`

## Requirements
- R1: Out of reset, req_ready_o is 1, rsp_valid_o is 0 and mem_req_valid_o is 0.
- R2: A read hit raises rsp_valid_o 4 clock edges after the accepting edge. rsp_rdata_o holds the whole line, with the word at line offset 8*k in bits [64k+63:64k].
- R3: A clean miss with memory delay D completes 12+D edges after acceptance. D is the number of edges from the read-request handshake to the first response beat, with the beats on consecutive cycles. The read request carries the line address (offset bits zero), and four response beats fill the line in ascending order. A request held without ready keeps its address and direction.
- R4: Eight different tags mapping to one set are all resident at once. Every word of each of them then hits in 4 edges.
- R5: With all ways valid, the victim follows a tree pseudo-LRU. Each node points away from the last way touched below it, and the tree is updated on every hit and every fill. With any way invalid, an invalid way is filled instead.
- R6: A write replaces the 64-bit word selected by address bits [4:3] and leaves the rest of the line. A write hit takes 4 edges. A write miss allocates the line with miss timing. Backing memory is not updated by the write.
- R7: When the victim is dirty, four write beats to the victim line, in ascending word order, precede the read request, and the access takes 16+D edges. The written-back data reaches backing memory.
- R8: With enable_i low at acceptance, a read takes 9+D edges and returns memory data. A write issues one write beat at the word address and takes 6 edges. Neither touches tags, data or replacement state.
- R9: req_ready_o stays low from the accepting edge until the edge after rsp_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Cache enable, sampled with the request |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle and accepting |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 64 | Write word |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 256 | Line data for reads |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | 1 = write beat, 0 = line read |
| mem_req_addr_o | output | AW | Beat address for writes, line address for reads |
| mem_req_wdata_o | output | 64 | Write beat data |
| mem_rsp_valid_i | input | 1 | Read response beat valid |
| mem_rsp_data_i | input | 64 | Read response beat data |

## Verification
The bench builds the block with a 12-bit address and four sets of eight ways. That leaves a 5-bit tag, so nine tags aimed at one set force replacement, and every way and word offset of a set can be swept quickly. A whole set is filled and every word of it is read back. Then a fixed chain of misses and hits exercises the pseudo-LRU tree, and a dirty eviction is followed back to memory. The memory model takes two different response delays, so the latency formulas are checked in D and not only against a single constant.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int OFFS_W   = 5;
  localparam int BEAT_W   = 64;
  localparam int BEATS    = 4;
  localparam int LINE_W   = BEAT_W * BEATS;
  localparam int PEN_CYC  = 2;
  localparam int DATA_LAT = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOOKUP, ST_PEN_REQ, ST_WB, ST_RD_REQ,
    ST_RD_BEAT, ST_PEN_RET, ST_BYP_WR, ST_DATA, ST_RESP
  } ctl_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 8,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAYS-1:0]  valid_o,
  output logic [WAYS-1:0]  dirty_o,
  input  logic [WAY_W-1:0] rd_way_i,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             fill_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             fill_dirty_i,
  input  logic             set_dirty_i,
  input  logic [WAY_W-1:0] dirty_way_i
);
  logic [TAG_W-1:0] tag_mem [SETS*WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAYS-1:0]  hit_vec;

  assign valid_o  = valid_q[idx_i];
  assign dirty_o  = dirty_q[idx_i];
  assign rd_tag_o = tag_mem[{idx_i, rd_way_i}];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[idx_i][w] &&
                        (tag_mem[{idx_i, WAY_W'(w)}] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
  end
  assign hit_o = |hit_vec;

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_mem[{idx_i, fill_way_i}] <= tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (fill_i) begin
      valid_q[idx_i][fill_way_i] <= 1'b1;
      dirty_q[idx_i][fill_way_i] <= fill_dirty_i;
    end else if (set_dirty_i) begin
      dirty_q[idx_i][dirty_way_i] <= 1'b1;
    end
  end

  // R4
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/cache_plru.sv
module cache_plru #(
  parameter int SETS = 16,
  parameter int WAYS = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAYS-2:0] tree_q [SETS];
  logic [WAYS-2:0] tree_nxt;

  // node bit 0: victim lies in lower half
  always_comb begin
    int node;
    logic b;
    node = 0;
    victim_o = '0;
    for (int l = 0; l < WAY_W; l++) begin
      b = tree_q[idx_i][node];
      victim_o[WAY_W-1-l] = b;
      node = 2 * node + 1 + int'(b);
    end
  end

  always_comb begin
    int node;
    logic b;
    node = 0;
    tree_nxt = tree_q[idx_i];
    for (int l = 0; l < WAY_W; l++) begin
      b = touch_way_i[WAY_W-1-l];
      tree_nxt[node] = ~b;
      node = 2 * node + 1 + int'(b);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_i) begin
      tree_q[idx_i] <= tree_nxt;
    end
  end
endmodule

// File: rtl/cache_data_array.sv
module cache_data_array
  import cache_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 8,
  parameter int LAT  = DATA_LAT,
  localparam int ENT   = SETS * WAYS,
  localparam int IDX_W = $clog2(ENT),
  localparam int CNT_W = $clog2(LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              wr_i,
  input  logic [1:0]        wsel_i,
  input  logic [BEAT_W-1:0] wdata_i,
  output logic [LINE_W-1:0] rdata_o,
  output logic              done_o,
  input  logic [IDX_W-1:0]  peek_idx_i,
  output logic [LINE_W-1:0] peek_line_o
);
  logic [LINE_W-1:0] mem [ENT];
  logic [LINE_W-1:0] new_line;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    new_line = fill_i ? fill_line_i : mem[idx_i];
    if (wr_i) new_line[wsel_i*BEAT_W +: BEAT_W] = wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (start_i) begin
      if (fill_i || wr_i) mem[idx_i] <= new_line;
      rdata_o <= new_line;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CNT_W'(LAT);
    else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o      = (cnt_q == CNT_W'(1));
  assign peek_line_o = mem[peek_idx_i];

  // R2
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q == '0);
  // R2
  lat_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/two_phase_cache.sv
module two_phase_cache
  import cache_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SETS = 16,
  parameter int WAYS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [BEAT_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [LINE_W-1:0] rsp_rdata_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [AW-1:0]     mem_req_addr_o,
  output logic [BEAT_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [BEAT_W-1:0] mem_rsp_data_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = AW - IDX_W - OFFS_W;
  localparam int CNT_W = $clog2(BEATS);

  ctl_state_e         state_q;
  logic [AW-1:0]      addr_q;
  logic               write_q, en_q, vic_dirty_q;
  logic [BEAT_W-1:0]  wdata_q;
  logic [WAY_W-1:0]   way_q;
  logic [TAG_W-1:0]   vic_tag_q;
  logic [LINE_W-1:0]  vic_line_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BEAT_W-1:0]  fill_q [BEATS];
  logic [LINE_W-1:0]  fill_line;

  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic               hit;
  logic [WAY_W-1:0]   hit_way, plru_way, vic_way, da_way;
  logic [WAYS-1:0]    valid_set, dirty_set;
  logic [TAG_W-1:0]   rd_tag;
  logic               pen_last, da_start, da_fill, da_done, tag_fill, set_dirty;
  logic [LINE_W-1:0]  da_rdata, peek_line;

  assign idx = addr_q[OFFS_W +: IDX_W];
  assign tag = addr_q[AW-1 -: TAG_W];

  always_comb begin
    for (int b = 0; b < BEATS; b++) fill_line[b*BEAT_W +: BEAT_W] = fill_q[b];
  end

  // invalid way first, else tree choice
  always_comb begin
    vic_way = plru_way;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_set[w]) vic_way = WAY_W'(w);
  end

  assign pen_last  = (cnt_q == CNT_W'(PEN_CYC - 1));
  assign da_start  = (state_q == ST_LOOKUP && en_q && hit) ||
                     (state_q == ST_PEN_RET && en_q && pen_last);
  assign da_fill   = (state_q == ST_PEN_RET);
  assign da_way    = (state_q == ST_LOOKUP) ? hit_way : way_q;
  assign tag_fill  = (state_q == ST_PEN_RET) && en_q && pen_last;
  assign set_dirty = (state_q == ST_LOOKUP) && en_q && hit && write_q;

  cache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .idx_i(idx), .tag_i(tag),
    .hit_o(hit), .hit_way_o(hit_way),
    .valid_o(valid_set), .dirty_o(dirty_set),
    .rd_way_i(vic_way), .rd_tag_o(rd_tag),
    .fill_i(tag_fill), .fill_way_i(way_q), .fill_dirty_i(write_q),
    .set_dirty_i(set_dirty), .dirty_way_i(hit_way)
  );

  cache_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk_i, .rst_ni,
    .idx_i(idx), .touch_i(da_start), .touch_way_i(da_way),
    .victim_o(plru_way)
  );

  cache_data_array #(.SETS(SETS), .WAYS(WAYS), .LAT(DATA_LAT)) u_data (
    .clk_i, .rst_ni,
    .start_i(da_start), .idx_i({idx, da_way}),
    .fill_i(da_fill), .fill_line_i(fill_line),
    .wr_i(write_q), .wsel_i(addr_q[4:3]), .wdata_i(wdata_q),
    .rdata_o(da_rdata), .done_o(da_done),
    .peek_idx_i({idx, vic_way}), .peek_line_o(peek_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      write_q     <= 1'b0;
      wdata_q     <= '0;
      en_q        <= 1'b0;
      way_q       <= '0;
      vic_dirty_q <= 1'b0;
      vic_tag_q   <= '0;
      vic_line_q  <= '0;
      cnt_q       <= '0;
      for (int b = 0; b < BEATS; b++) fill_q[b] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          write_q <= req_write_i;
          wdata_q <= req_wdata_i;
          en_q    <= enable_i;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          cnt_q <= '0;
          if (en_q && hit) begin
            state_q <= ST_DATA;
          end else begin
            way_q       <= vic_way;
            vic_dirty_q <= en_q && valid_set[vic_way] && dirty_set[vic_way];
            vic_tag_q   <= rd_tag;
            vic_line_q  <= peek_line;
            state_q     <= ST_PEN_REQ;
          end
        end
        ST_PEN_REQ: if (pen_last) begin
          cnt_q <= '0;
          if (!en_q)            state_q <= write_q ? ST_BYP_WR : ST_RD_REQ;
          else if (vic_dirty_q) state_q <= ST_WB;
          else                  state_q <= ST_RD_REQ;
        end else cnt_q <= cnt_q + CNT_W'(1);
        ST_WB: if (mem_req_ready_i) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(BEATS - 1)) state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_req_ready_i) begin
          cnt_q   <= '0;
          state_q <= ST_RD_BEAT;
        end
        ST_RD_BEAT: if (mem_rsp_valid_i) begin
          fill_q[cnt_q] <= mem_rsp_data_i;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(BEATS - 1)) state_q <= ST_PEN_RET;
        end
        ST_BYP_WR: if (mem_req_ready_i) begin
          cnt_q   <= '0;
          state_q <= ST_PEN_RET;
        end
        ST_PEN_RET: if (pen_last) begin
          cnt_q   <= '0;
          state_q <= en_q ? ST_DATA : ST_RESP;
        end else cnt_q <= cnt_q + CNT_W'(1);
        ST_DATA: if (da_done) state_q <= ST_RESP;
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_rdata_o     = en_q ? da_rdata : fill_line;
  assign mem_req_valid_o = (state_q == ST_WB) || (state_q == ST_RD_REQ) ||
                           (state_q == ST_BYP_WR);
  assign mem_req_write_o = (state_q == ST_WB) || (state_q == ST_BYP_WR);

  always_comb begin
    mem_req_addr_o  = '0;
    mem_req_wdata_o = '0;
    unique case (state_q)
      ST_WB: begin
        mem_req_addr_o  = {vic_tag_q, idx, cnt_q, 3'b000};
        mem_req_wdata_o = vic_line_q[cnt_q*BEAT_W +: BEAT_W];
      end
      ST_RD_REQ: mem_req_addr_o = {tag, idx, {OFFS_W{1'b0}}};
      ST_BYP_WR: begin
        mem_req_addr_o  = {addr_q[AW-1:3], 3'b000};
        mem_req_wdata_o = wdata_q;
      end
      default: ;
    endcase
  end

  // R9
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R3
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)));
  // R8
  pen_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PEN_REQ && $past(state_q) != ST_PEN_REQ) |=> state_q == ST_PEN_REQ);
  // R5
  inv_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOKUP && en_q && !hit && !(&valid_set)) |-> !valid_set[vic_way]);
endmodule

// File: tb/two_phase_cache_test.sv
module two_phase_cache_test;
  localparam int AW = 12;
  localparam int SETS = 4;
  localparam int WAYS = 8;
  localparam int CYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [255:0] rsp_rdata;
  logic mreq_valid, mreq_write;
  logic [AW-1:0] mreq_addr;
  logic [63:0] mreq_wdata;
  logic mrsp_valid = 1'b0;
  logic [63:0] mrsp_data = '0;

  always #(CYC/2) clk = ~clk;

  two_phase_cache #(.AW(AW), .SETS(SETS), .WAYS(WAYS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(1'b1),
    .mem_req_write_o(mreq_write), .mem_req_addr_o(mreq_addr),
    .mem_req_wdata_o(mreq_wdata),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_data_i(mrsp_data)
  );

  logic [63:0] back_mem [512];
  logic [63:0] ref_mem  [512];
  int mem_dly = 2;
  int n_chk = 0, n_bad = 0, busy_bad = 0;
  int ev_n = 0;
  logic [AW-1:0] ev_addr [16];
  logic          ev_wr   [16];
  bit done = 0;

  function automatic logic [AW-1:0] mk_addr(int t, int s, int w);
    return AW'((t << 7) | (s << 5) | (w << 3));
  endfunction

  function automatic logic [255:0] exp_line(int t, int s);
    int base;
    base = int'(mk_addr(t, s, 0) >> 3);
    return {ref_mem[base+3], ref_mem[base+2], ref_mem[base+1], ref_mem[base]};
  endfunction

  task automatic chk(input bit ok, input string msg, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", msg, act, exp);
    end
  endtask

  task automatic chk_i(input string msg, input int act, input int exp);
    chk(act == exp, msg, 256'(act), 256'(exp));
  endtask

  // memory model: ready always high, read beats D edges after handshake
  initial begin
    bit act;
    int k;
    int base;
    act = 0; k = 0; base = 0;
    for (int i = 0; i < 512; i++) begin
      back_mem[i] = {16'hBEEF ^ 16'(i), 16'(i), 32'(i) * 32'h9E37_79B1};
      ref_mem[i]  = back_mem[i];
    end
    forever begin
      @(negedge clk);
      mrsp_valid = 1'b0;
      if (act) begin
        k++;
        if (k >= mem_dly) begin
          mrsp_valid = 1'b1;
          mrsp_data  = back_mem[base + k - mem_dly];
          if (k - mem_dly == 3) act = 0;
        end
      end
      if (rst_n && mreq_valid) begin
        if (ev_n < 16) begin
          ev_addr[ev_n] = mreq_addr;
          ev_wr[ev_n]   = mreq_write;
        end
        ev_n++;
        if (mreq_write) back_mem[int'(mreq_addr >> 3)] = mreq_wdata;
        else begin
          act = 1; k = 0; base = int'(mreq_addr >> 3);
        end
      end
    end
  end

  task automatic access(input bit wr, input bit en, input int t, input int s, input int w,
                        input logic [63:0] wd, output int lat, output logic [255:0] line);
    int k;
    @(negedge clk);
    if (!req_ready) busy_bad++;
    req_valid = 1'b1; req_write = wr; req_addr = mk_addr(t, s, w);
    req_wdata = wd; enable = en;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) ref_mem[int'(mk_addr(t, s, w) >> 3)] = wd;
    k = 0;
    while (!rsp_valid && k < 300) begin
      if (req_ready) busy_bad++;
      @(posedge clk);
      k++;
      @(negedge clk);
    end
    lat = k;
    line = rsp_rdata;
  endtask

  task automatic rd(input bit en, input int t, input int s, input int exp_lat, input string tagl);
    int lat;
    logic [255:0] line;
    access(1'b0, en, t, s, 0, 64'h0, lat, line);
    chk_i({tagl, " latency"}, lat, exp_lat);
    chk(line == exp_line(t, s), {tagl, " data"}, line, exp_line(t, s));
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CYC * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    int lat;
    logic [255:0] line;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", 256'(req_ready), 256'(1));
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 256'(rsp_valid), 256'(0));
    chk(mreq_valid == 1'b0, "R1 mem_req_valid", 256'(mreq_valid), 256'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 clean fills of set 0, invalid ways first (R5)
    for (int t = 0; t < 8; t++) begin
      ev_n = 0;
      rd(1'b1, t, 0, 12 + mem_dly, "R3 fill");
      chk_i("R3 single read request", ev_n, 1);
      chk(ev_addr[0] == mk_addr(t, 0, 0) && !ev_wr[0], "R3 line address",
          256'(ev_addr[0]), 256'(mk_addr(t, 0, 0)));
    end

    // R4 every way, every word offset hits with the full line (R2)
    for (int t = 0; t < 8; t++) begin
      for (int w = 0; w < 4; w++) begin
        access(1'b0, 1'b1, t, 0, w, 64'h0, lat, line);
        chk_i("R4 hit latency", lat, 4);
        chk(line == exp_line(t, 0), "R2 hit line", line, exp_line(t, 0));
      end
    end

    // R5 pseudo-LRU chain in set 0
    rd(1'b1, 8, 0, 12 + mem_dly, "R5 tag8 miss evicts way0");
    rd(1'b1, 0, 0, 12 + mem_dly, "R5 tag0 miss evicts way4");
    rd(1'b1, 1, 0, 4, "R5 tag1 hit");
    rd(1'b1, 2, 0, 4, "R5 tag2 hit");
    rd(1'b1, 4, 0, 12 + mem_dly, "R5 tag4 miss evicts way6");
    rd(1'b1, 8, 0, 4, "R5 tag8 hit");
    rd(1'b1, 5, 0, 4, "R5 tag5 hit");
    rd(1'b1, 6, 0, 12 + mem_dly, "R5 tag6 miss");

    // R6 write-allocate and write hit merge in set 1
    access(1'b1, 1'b1, 0, 1, 2, 64'h1111_2222_3333_4444, lat, line);
    chk_i("R6 write miss latency", lat, 12 + mem_dly);
    rd(1'b1, 0, 1, 4, "R6 merged word2");
    access(1'b1, 1'b1, 0, 1, 1, 64'h5555_6666_7777_8888, lat, line);
    chk_i("R6 write hit latency", lat, 4);
    rd(1'b1, 0, 1, 4, "R6 merged word1");
    chk(back_mem[int'(mk_addr(0, 1, 2) >> 3)] != 64'h1111_2222_3333_4444,
        "R6 memory untouched", back_mem[int'(mk_addr(0, 1, 2) >> 3)], 256'(0));

    // R7 dirty victim write-back
    for (int t = 1; t < 8; t++) rd(1'b1, t, 1, 12 + mem_dly, "R7 fill set1");
    ev_n = 0;
    rd(1'b1, 8, 1, 16 + mem_dly, "R7 dirty eviction");
    chk_i("R7 event count", ev_n, 5);
    for (int b = 0; b < 4; b++)
      chk(ev_wr[b] && ev_addr[b] == mk_addr(0, 1, b), "R7 write-back beat order",
          256'(ev_addr[b]), 256'(mk_addr(0, 1, b)));
    chk(!ev_wr[4] && ev_addr[4] == mk_addr(8, 1, 0), "R7 refill after write-back",
        256'(ev_addr[4]), 256'(mk_addr(8, 1, 0)));
    chk(back_mem[int'(mk_addr(0, 1, 1) >> 3)] == 64'h5555_6666_7777_8888 &&
        back_mem[int'(mk_addr(0, 1, 2) >> 3)] == 64'h1111_2222_3333_4444,
        "R7 memory holds dirty words", back_mem[int'(mk_addr(0, 1, 2) >> 3)],
        256'(64'h1111_2222_3333_4444));
    rd(1'b1, 0, 1, 12 + mem_dly, "R7 refetch evicted line");

    // R8 bypass
    rd(1'b1, 3, 2, 12 + mem_dly, "R8 prime set2");
    rd(1'b0, 3, 2, 9 + mem_dly, "R8 bypass read");
    ev_n = 0;
    access(1'b1, 1'b0, 5, 2, 1, 64'hABCD_0000_1234_5678, lat, line);
    chk_i("R8 bypass write latency", lat, 6);
    chk_i("R8 bypass write beats", ev_n, 1);
    chk(ev_wr[0] && ev_addr[0] == mk_addr(5, 2, 1), "R8 bypass write address",
        256'(ev_addr[0]), 256'(mk_addr(5, 2, 1)));
    rd(1'b1, 3, 2, 4, "R8 cache untouched");
    rd(1'b1, 5, 2, 12 + mem_dly, "R8 write not allocated");

    // R3 other memory delay
    mem_dly = 5;
    rd(1'b1, 0, 3, 12 + mem_dly, "R3 delay5 miss");
    rd(1'b0, 9, 3, 9 + mem_dly, "R8 delay5 bypass");
    rd(1'b1, 0, 3, 4, "R2 delay5 hit");

    // R9 ready low for the whole of every access
    chk_i("R9 busy ready", busy_bad, 0);
    finish_run();
  end
endmodule